// File: doc/BRIEF.md
# Multi-Line Receive Queue with Status Word

This block collects received characters from several serial lines into one shared queue. Each line's deserialiser is represented by a per-line character strobe, which comes with a character byte, framing and parity error inputs, and a break indication. Each accepted character is stored together with its source line number and its error flags. Characters from all lines are interleaved in arrival order in a single queue, so software reads one register no matter which line delivered the data.

Software reads the head of the queue through a 16-bit receive word. A valid bit marks the word as holding data. Each read strobe removes the head entry, and software empties the queue by reading until the valid bit is clear. A done flag shows that data is waiting. An interrupt request is raised only when the done flag is set and the receive interrupt enable is set. Each line has its own parameter word, holding a receiver enable, a character size and a parity enable. A control write with the clear bit set flushes the queue and turns off every receiver.

Top module: `rxq_top`

## Requirements
- R1: The receive word is laid out as follows: bit 15 valid, bit 14 overrun, bit 13 framing error, bit 12 parity error, bits 11:8 source line number, bits 7:0 character. When the queue is empty the whole word reads 0x0000.
- R2: A read strobe while the queue holds data removes the head entry. Entries come out in the order they were stored. A read strobe on an empty queue has no effect.
- R3: rx_done is high exactly while the queue holds at least one entry. rx_irq is high only when rx_done is high and the interrupt enable is set. The enable is written through csr_rie when csr_we is high.
- R4: A character strobe on a line whose receiver enable is 0 is discarded. After reset, every receiver is disabled.
- R5: The character size code of each line selects the number of data bits kept: 0 keeps 5 bits, 1 keeps 6, 2 keeps 7 and 3 keeps 8. Data bits above the selected size are stored as zero.
- R6: The framing error input is always stored. The parity error input is stored only when parity is enabled for that line.
- R7: A break indication on a line stores character 0x00 with the framing error bit set. The word has no separate break bit.
- R8: When several enabled lines strobe in the same cycle, their entries are stored in ascending line number order.
- R9: The queue holds 16 entries. Free space is judged from the fill level at the start of the cycle. A character that finds no space is dropped, and the overrun bit is set on the next entry that is stored.
- R10: A control write with csr_clr set empties the queue, clears any pending overrun, disables every receiver, and discards any strobes in the same cycle.
- R11: After reset the queue is empty, rx_done and rx_irq are low, and the interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_strobe | input | 4 | One pulse per received character, one bit per line |
| line_char | input | 32 | Received character, 8 bits per line, line 0 in the low byte |
| line_ferr | input | 4 | Framing error, one bit per line |
| line_perr | input | 4 | Parity error, one bit per line |
| line_brk | input | 4 | Break indication, one bit per line |
| cfg_we | input | 1 | Write strobe for a line parameter word |
| cfg_line | input | 2 | Line selected by the parameter write |
| cfg_size | input | 2 | Character size code (0..3 selects 5..8 bits) |
| cfg_par_en | input | 1 | Parity enable for the selected line |
| cfg_rx_en | input | 1 | Receiver enable for the selected line |
| csr_we | input | 1 | Control write strobe |
| csr_clr | input | 1 | Clear bit of the control write |
| csr_rie | input | 1 | Receive interrupt enable value of the control write |
| rbuf_rd | input | 1 | Read strobe for the receive word; removes the head entry |
| rbuf_data | output | 16 | Receive word at the head of the queue |
| rx_done | output | 1 | The queue holds data |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hold property assumes that the receive word can change only through a read strobe, a line strobe or a control write. It therefore relies on line strobes being the only source of new entries. The bench never asserts a line strobe and a read strobe in the same cycle, so the bench's model of free space matches the fill level at the start of each cycle. Every input pulse lasts exactly one clock. Reset is held for several cycles before any property that looks into the past is enabled.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int CHAR_W       = 8;
    localparam int LINE_FIELD_W = 4;
    localparam int WORD_W       = 16;

    typedef enum logic [1:0] {
        SZ5 = 2'd0,
        SZ6 = 2'd1,
        SZ7 = 2'd2,
        SZ8 = 2'd3
    } char_size_e;

    typedef struct packed {
        logic                    ovr;
        logic                    ferr;
        logic                    perr;
        logic [LINE_FIELD_W-1:0] line;
        logic [CHAR_W-1:0]       data;
    } rx_entry_t;

    typedef struct packed {
        logic       en;
        char_size_e size;
        logic       par_en;
    } line_cfg_t;

    function automatic logic [CHAR_W-1:0] size_mask(char_size_e s);
        case (s)
            SZ5:     return 8'h1F;
            SZ6:     return 8'h3F;
            SZ7:     return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] to_word(logic valid, rx_entry_t e);
        return {valid, e};
    endfunction

endpackage

// File: rtl/rxq_line_cfg.sv
module rxq_line_cfg
    import rxq_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clr,
    input  logic                            we,
    input  logic [LINE_W-1:0]               sel,
    input  line_cfg_t                       wdata,
    output line_cfg_t [NUM_LINES-1:0]       cfg_o
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_o[i] <= '{en: 1'b0, size: SZ8, par_en: 1'b0};
            end else if (clr) begin
                cfg_o[i].en <= 1'b0;
            end else if (we && sel == LINE_W'(i)) begin
                cfg_o[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/rxq_merge.sv
module rxq_merge #(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 16,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int OFF_W    = $clog2(NUM_LINES + 1)
) (
    input  logic [CNT_W-1:0]                  count,
    input  logic [NUM_LINES-1:0]              act,
    output logic [NUM_LINES-1:0]              admit,
    output logic [NUM_LINES-1:0][OFF_W-1:0]   off,
    output logic [OFF_W-1:0]                  n_store,
    output logic                              drop_any
);

    always_comb begin
        int run;
        run      = 0;
        drop_any = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            off[i]   = OFF_W'(run);
            admit[i] = act[i] && ((int'(count) + run) < DEPTH);
            if (admit[i]) begin
                run = run + 1;
            end
            if (act[i] && !admit[i]) begin
                drop_any = 1'b1;
            end
        end
        n_store = OFF_W'(run);
    end

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 16,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int OFF_W    = $clog2(NUM_LINES + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              clr,
    input  logic [NUM_LINES-1:0]              admit,
    input  logic [NUM_LINES-1:0][OFF_W-1:0]   off,
    input  rx_entry_t [NUM_LINES-1:0]         wr_entry,
    input  logic [OFF_W-1:0]                  n_store,
    input  logic                              pop,
    output rx_entry_t                         head,
    output logic [CNT_W-1:0]                  count
);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (!rst && !clr && admit[i]) begin
                mem[wr_ptr + PTR_W'(off[i])] <= wr_entry[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(n_store);
            rd_ptr <= rd_ptr + PTR_W'(pop);
            count  <= count + CNT_W'(n_store) - CNT_W'(pop);
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 16,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int OFF_W    = $clog2(NUM_LINES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LINES-1:0]        line_strobe,
    input  logic [NUM_LINES*8-1:0]      line_char,
    input  logic [NUM_LINES-1:0]        line_ferr,
    input  logic [NUM_LINES-1:0]        line_perr,
    input  logic [NUM_LINES-1:0]        line_brk,
    input  logic                        cfg_we,
    input  logic [LINE_W-1:0]           cfg_line,
    input  logic [1:0]                  cfg_size,
    input  logic                        cfg_par_en,
    input  logic                        cfg_rx_en,
    input  logic                        csr_we,
    input  logic                        csr_clr,
    input  logic                        csr_rie,
    input  logic                        rbuf_rd,
    output logic [15:0]                 rbuf_data,
    output logic                        rx_done,
    output logic                        rx_irq
);

    logic                             clr;
    line_cfg_t [NUM_LINES-1:0]        cfg;
    line_cfg_t                        cfg_wdata;
    logic [NUM_LINES-1:0]             en_vec;
    logic [NUM_LINES-1:0]             act;
    logic [NUM_LINES-1:0]             admit;
    logic [NUM_LINES-1:0][OFF_W-1:0]  off;
    logic [OFF_W-1:0]                 n_store;
    logic                             drop_any;
    rx_entry_t [NUM_LINES-1:0]        wr_entry;
    rx_entry_t                        head;
    logic [CNT_W-1:0]                 q_count;
    logic                             pop;
    logic                             ovr_pend;
    logic                             rie;

    assign clr       = csr_we && csr_clr;
    assign cfg_wdata = '{en: cfg_rx_en, size: char_size_e'(cfg_size), par_en: cfg_par_en};

    rxq_line_cfg #(.NUM_LINES(NUM_LINES)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .we    (cfg_we),
        .sel   (cfg_line),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_entry
        assign en_vec[i] = cfg[i].en;
        always_comb begin
            wr_entry[i].ovr  = ovr_pend && (off[i] == '0);
            wr_entry[i].ferr = line_ferr[i] || line_brk[i];
            wr_entry[i].perr = line_perr[i] && cfg[i].par_en;
            wr_entry[i].line = LINE_FIELD_W'(i);
            wr_entry[i].data = line_brk[i] ? '0
                             : (line_char[i*CHAR_W +: CHAR_W] & size_mask(cfg[i].size));
        end
    end

    assign act = line_strobe & en_vec & {NUM_LINES{!clr}};

    rxq_merge #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) u_merge (
        .count    (q_count),
        .act      (act),
        .admit    (admit),
        .off      (off),
        .n_store  (n_store),
        .drop_any (drop_any)
    );

    assign pop = rbuf_rd && (q_count != '0) && !clr;

    rxq_fifo #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .admit    (admit),
        .off      (off),
        .wr_entry (wr_entry),
        .n_store  (n_store),
        .pop      (pop),
        .head     (head),
        .count    (q_count)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ovr_pend <= 1'b0;
        end else if (drop_any) begin
            ovr_pend <= 1'b1;
        end else if (n_store != '0) begin
            ovr_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rie <= 1'b0;
        end else if (csr_we) begin
            rie <= csr_rie;
        end
    end

    assign rx_done   = (q_count != '0);
    assign rbuf_data = rx_done ? to_word(1'b1, head) : '0;
    assign rx_irq    = rx_done && rie;

endmodule

// File: rtl/rxq_checks.sv
module rxq_checks #(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 16,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] line_strobe,
    input logic                 csr_we,
    input logic                 csr_clr,
    input logic                 rbuf_rd,
    input logic [15:0]          rbuf_data,
    input logic                 rx_done,
    input logic                 rx_irq,
    input logic [CNT_W-1:0]     q_count
);

    p_empty_word_r1: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> (rbuf_data == 16'h0000));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!rbuf_rd && line_strobe == '0 && !csr_we) |=> (rbuf_data == $past(rbuf_data)));

    p_irq_data_r3: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rbuf_data[15]);

    p_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!rx_done && line_strobe == '0) |=> !rx_done);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        int'(q_count) <= DEPTH);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_clr) |=> !rx_done);

endmodule

bind rxq_top rxq_checks #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_strobe (line_strobe),
    .csr_we      (csr_we),
    .csr_clr     (csr_clr),
    .rbuf_rd     (rbuf_rd),
    .rbuf_data   (rbuf_data),
    .rx_done     (rx_done),
    .rx_irq      (rx_irq),
    .q_count     (q_count)
);

// File: tb/sim_rxq_top.sv
module sim_rxq_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic [3:0]  line_strobe, line_ferr, line_perr, line_brk;
    logic [31:0] line_char;
    logic        cfg_we, cfg_par_en, cfg_rx_en;
    logic [1:0]  cfg_line, cfg_size;
    logic        csr_we, csr_clr, csr_rie, rbuf_rd;
    logic [15:0] rbuf_data;
    logic        rx_done, rx_irq;

    rxq_top u0 (
        .clk(clk), .rst(rst), .line_strobe(line_strobe), .line_char(line_char),
        .line_ferr(line_ferr), .line_perr(line_perr), .line_brk(line_brk),
        .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_size(cfg_size),
        .cfg_par_en(cfg_par_en), .cfg_rx_en(cfg_rx_en), .csr_we(csr_we),
        .csr_clr(csr_clr), .csr_rie(csr_rie), .rbuf_rd(rbuf_rd),
        .rbuf_data(rbuf_data), .rx_done(rx_done), .rx_irq(rx_irq)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 0;
    logic [15:0] expq[$];
    bit          m_en [4];
    logic [1:0]  m_sz [4];
    bit          m_pe [4];
    bit          m_ovr;
    bit          m_rie;

    task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_line(int ln, bit en, logic [1:0] sz, bit pe);
        @(negedge clk);
        cfg_we = 1; cfg_line = 2'(ln); cfg_rx_en = en; cfg_size = sz; cfg_par_en = pe;
        @(negedge clk);
        cfg_we = 0;
        m_en[ln] = en; m_sz[ln] = sz; m_pe[ln] = pe;
    endtask

    task automatic write_csr(bit clr_b, bit rie_b);
        @(negedge clk);
        csr_we = 1; csr_clr = clr_b; csr_rie = rie_b;
        @(negedge clk);
        csr_we = 0; csr_clr = 0;
        m_rie = rie_b;
        if (clr_b) begin
            expq.delete();
            m_ovr = 0;
            for (int i = 0; i < 4; i++) m_en[i] = 0;
        end
    endtask

    task automatic send(logic [3:0] stb, logic [31:0] ch, logic [3:0] fe,
                        logic [3:0] pe, logic [3:0] bk);
        @(negedge clk);
        line_strobe = stb; line_char = ch; line_ferr = fe; line_perr = pe; line_brk = bk;
        for (int i = 0; i < 4; i++) begin
            if (stb[i] && m_en[i]) begin
                if (expq.size() < 16) begin
                    logic [7:0] d;
                    d = bk[i] ? 8'h00 : (ch[i*8 +: 8] & (8'hFF >> (3 - m_sz[i])));
                    expq.push_back({1'b1, m_ovr, fe[i] | bk[i], pe[i] & m_pe[i], 4'(i), d});
                    m_ovr = 0;
                end else begin
                    m_ovr = 1;
                end
            end
        end
        @(negedge clk);
        line_strobe = 0; line_ferr = 0; line_perr = 0; line_brk = 0;
    endtask

    task automatic read_one(string tag);
        @(negedge clk);
        chk(rbuf_data == expq[0], tag, rbuf_data, expq[0]);
        void'(expq.pop_front());
        rbuf_rd = 1;
        @(negedge clk);
        rbuf_rd = 0;
    endtask

    task automatic drain(string tag);
        @(negedge clk);
        while (expq.size() > 0) begin
            chk(rbuf_data == expq[0], tag, rbuf_data, expq[0]);
            void'(expq.pop_front());
            rbuf_rd = 1;
            @(negedge clk);
            rbuf_rd = 0;
        end
        chk(rbuf_data == 16'h0, {tag, " R1 empty word"}, rbuf_data, 16'h0);
        chk(rx_done == 0, {tag, " R3 done low"}, 16'(rx_done), 16'h0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; line_strobe = 0; line_char = 0; line_ferr = 0; line_perr = 0; line_brk = 0;
        cfg_we = 0; cfg_line = 0; cfg_size = 0; cfg_par_en = 0; cfg_rx_en = 0;
        csr_we = 0; csr_clr = 0; csr_rie = 0; rbuf_rd = 0;
        m_ovr = 0; m_rie = 0;
        for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_sz[i] = 3; m_pe[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;

        // R11 reset state
        @(negedge clk);
        chk(rbuf_data == 16'h0, "R11 reset word", rbuf_data, 16'h0);
        chk(rx_done == 0, "R11 reset done", 16'(rx_done), 16'h0);
        chk(rx_irq == 0, "R11 reset irq", 16'(rx_irq), 16'h0);

        // R4 receivers disabled after reset
        send(4'b0001, 32'h0000_0041, 0, 0, 0);
        @(negedge clk);
        chk(rx_done == 0, "R4 disabled at reset", 16'(rx_done), 16'h0);

        // R1 R3 single character, irq gated by enable
        for (int i = 0; i < 4; i++) set_line(i, 1, 2'd3, 0);
        send(4'b0100, 32'h0055_0000, 0, 0, 0);
        @(negedge clk);
        chk(rx_done == 1, "R3 done high", 16'(rx_done), 16'h1);
        chk(rx_irq == 0, "R3 irq masked", 16'(rx_irq), 16'h0);
        write_csr(0, 1);
        @(negedge clk);
        chk(rx_irq == 1, "R3 irq asserted", 16'(rx_irq), 16'h1);
        drain("R1 single word");
        chk(rx_irq == 0, "R3 irq drops when empty", 16'(rx_irq), 16'h0);

        // R2 read on empty queue has no effect
        @(negedge clk); rbuf_rd = 1; @(negedge clk); rbuf_rd = 0;
        chk(rbuf_data == 16'h0, "R2 empty read", rbuf_data, 16'h0);
        send(4'b0010, 32'h0000_3300, 0, 0, 0);
        send(4'b0001, 32'h0000_0011, 0, 0, 0);
        drain("R2 order after empty read");

        // R8 same-cycle delivery on all lines
        send(4'b1111, 32'hA4B3_C2D1, 0, 0, 0);
        send(4'b1010, 32'h7700_6600, 0, 0, 0);
        drain("R8 ascending lines");

        // R5 size masking
        set_line(0, 1, 2'd0, 0);
        set_line(1, 1, 2'd1, 0);
        set_line(2, 1, 2'd2, 0);
        send(4'b1111, 32'hFFFF_FFFF, 0, 0, 0);
        drain("R5 size mask");

        // R6 parity gating, framing always; R7 break
        set_line(0, 1, 2'd3, 1);
        set_line(1, 1, 2'd3, 0);
        set_line(2, 1, 2'd3, 0);
        send(4'b0011, 32'h0000_2A2B, 4'b0000, 4'b0011, 0);
        send(4'b0100, 32'h0045_0000, 4'b0100, 4'b0000, 0);
        send(4'b1000, 32'h5A00_0000, 4'b0000, 4'b0000, 4'b1000);
        drain("R6 R7 error flags");

        // R4 disabling one line
        set_line(2, 0, 2'd3, 0);
        send(4'b0110, 32'h0099_8800, 0, 0, 0);
        drain("R4 disabled line");

        // R9 fill, drop, overrun on next stored
        for (int k = 0; k < 16; k++) send(4'b0001, 32'(k + 8'h30), 0, 0, 0);
        @(negedge clk);
        chk(rx_done == 1, "R9 full done", 16'(rx_done), 16'h1);
        send(4'b0001, 32'h0000_00E1, 0, 0, 0);
        send(4'b0010, 32'h0000_E200, 0, 0, 0);
        read_one("R9 head after drop");
        send(4'b0010, 32'h0000_7100, 0, 0, 0);
        send(4'b0001, 32'h0000_0072, 0, 0, 0);
        drain("R9 overrun flag");

        // R10 clear empties queue and disables receivers
        send(4'b0011, 32'h0000_1213, 0, 0, 0);
        write_csr(1, 1);
        @(negedge clk);
        chk(rx_done == 0, "R10 clear empties", 16'(rx_done), 16'h0);
        chk(rbuf_data == 16'h0, "R10 clear word", rbuf_data, 16'h0);
        send(4'b1111, 32'h1111_1111, 0, 0, 0);
        @(negedge clk);
        chk(rx_done == 0, "R10 receivers off", 16'(rx_done), 16'h0);
        set_line(3, 1, 2'd3, 0);
        send(4'b1000, 32'h6C00_0000, 0, 0, 0);
        drain("R10 after reenable");

        finished = 1;
        summary();
        $finish;
    end

endmodule